// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a system and turns a two-step port sequence into single configuration requests toward a PCI-style fabric. Software first writes a 32-bit selector word to the address port at IO address 0x0CF8. The word names an enable flag, a bus, a device, a function and a register index. It then reads or writes the data port at 0x0CFC through 0x0CFF. When the selector is enabled, each data-port access issues exactly one configuration request. The request carries a formatted address word, per-byte enables, lane-aligned write data and a direction flag.

The host side is a plain valid/ready port. The host raises `host_valid` and holds its address, size, direction and write data steady until it sees `host_ready` high for one cycle. The access completes on that clock edge, and `host_rdata` is valid in the same cycle. The bridge stalls the host for as long as the fabric takes to answer. The fabric side uses two valid/ready channels. A request is held, with stable contents, until `cfg_req_ready` accepts it. A response is taken in any cycle where both `cfg_rsp_valid` and `cfg_rsp_ready` are high. `cfg_rsp_ready` is high only while a response is awaited. Only one request is outstanding at a time.

The address word picks its encoding from the latched bus number. Bus zero gives a local-segment (type 0) word. Any other bus gives a forwarded (type 1) word. Partial data-port accesses are lane-steered by the low two IO address bits.

Top module: `cfg_port_bridge`

## Requirements
- R1: A word-size (host_size=2) write to the address port 0x0CF8 stores the selector as written, except that bits 30:24 and 1:0 are forced to zero. The fields are enable in bit 31, bus in 23:16, device in 15:11, function in 10:8 and register in 7:2. A read of the address port returns the stored selector.
- R2: With the latched bus at zero, `cfg_req_addr` is {8'h00, 8'h00, device, function, register, 2'b00}.
- R3: With a nonzero latched bus, `cfg_req_addr` is {8'h00, bus, device, function, register, 2'b01}, so bits 31:24 are zero.
- R4: A data-port access while the enable bit is clear raises no request. A read returns 32'hFFFFFFFF and a write is discarded.
- R5: `cfg_req_be` covers the bytes of the access, starting at lane L = host_addr[1:0]. Size codes are 0 = byte (one lane), 1 = halfword (two lanes) and 2 = word (four lanes). Lanes above 3 are dropped.
- R6: `cfg_req_wdata` is `host_wdata` shifted left by 8·L bits.
- R7: Read data to the host is the response word shifted right by 8·L bits. It is then zero-extended above 8 bits for a byte access and above 16 bits for a halfword access.
- R8: An enabled data-port access issues exactly one request. `cfg_req_valid` and its contents hold until accepted. `host_ready` rises only in the cycle after the response is taken.
- R9: The stored selector does not change while a request is outstanding.
- R10: Partial-size writes to the address port are ignored. Accesses to any other IO address raise no request, return 32'hFFFFFFFF on reads, and change nothing.
- R11: After reset, `host_ready` and `cfg_req_valid` are low and the selector reads as zero, so the enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access pending |
| host_ready | output | 1 | Access completes this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | IO address of the access |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word |
| host_wdata | input | 32 | Host write data, right-aligned |
| host_rdata | output | 32 | Read data, valid with host_ready |
| cfg_req_valid | output | 1 | Configuration request pending |
| cfg_req_ready | input | 1 | Fabric accepts the request |
| cfg_req_write | output | 1 | Request direction |
| cfg_req_addr | output | 32 | Type 0 or type 1 address word |
| cfg_req_be | output | 4 | Byte enables |
| cfg_req_wdata | output | 32 | Lane-aligned write data |
| cfg_rsp_valid | input | 1 | Fabric response present |
| cfg_rsp_ready | output | 1 | Bridge awaits a response |
| cfg_rsp_rdata | input | 32 | Response data word |

## Verification
A corrupted selector shows up at the ports within one access. It appears in the next address-port readback, and in `cfg_req_addr` on the next enabled data-port access. A wrong type bit or bus field is visible in the request cycle itself. A sequencer that leaves its state early or late shows a missing or duplicate request, or a `host_ready` that arrives before the response. A lane error shows up in `cfg_req_be` and `cfg_req_wdata` when the request is issued, and in `host_rdata` in the completion cycle. The bench therefore scores every request against an expected queue and every read value against a value it computes itself.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] regn;
  } cfg_sel_t;

  // Bits of the selector word that are kept; all others read as zero.
  localparam logic [31:0] SEL_KEEP_MASK = 32'h80FF_FFFC;

endpackage

// File: rtl/cfgb_sel_reg.sv
module cfgb_sel_reg
  import cfgb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output logic          sel_en,
  output logic [DW-1:0] sel_word,
  output logic [31:0]   req_addr
);

  logic [31:0] q;
  cfg_sel_t    sel;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (we) q <= wdata[31:0] & SEL_KEEP_MASK;
  end

  assign sel.en   = q[31];
  assign sel.bus  = q[23:16];
  assign sel.dev  = q[15:11];
  assign sel.fn   = q[10:8];
  assign sel.regn = q[7:2];

  logic [1:0] type_bits;
  assign type_bits = (sel.bus != 8'h00) ? 2'b01 : 2'b00;

  assign sel_en   = sel.en;
  assign sel_word = DW'(q);
  assign req_addr = {8'h00, sel.bus, sel.dev, sel.fn, sel.regn, type_bits};

  // R9
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(q));

endmodule

// File: rtl/cfgb_lane.sv
module cfgb_lane
  import cfgb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [$clog2(DW/8)-1:0] lane,
  input  logic [1:0]              size,
  input  logic [DW-1:0]           wdata,
  input  logic [DW-1:0]           rsp_data,
  output logic [DW/8-1:0]         be,
  output logic [DW-1:0]           req_wdata,
  output logic [DW-1:0]           host_data
);

  localparam int NL = DW / 8;
  localparam int LW = $clog2(NL);
  localparam int CW = LW + 1;

  logic [CW-1:0] nb;
  logic [CW-1:0] lane_x;
  logic [CW-1:0] lane_end;
  logic [DW-1:0] shifted;

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: nb = CW'(1);
      SZ_HALF: nb = CW'(2);
      default: nb = CW'(NL);
    endcase
  end

  assign lane_x    = {1'b0, lane};
  assign lane_end  = lane_x + nb;
  assign shifted   = rsp_data >> {lane, 3'b000};
  assign req_wdata = wdata << {lane, 3'b000};

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign be[i] = (CW'(i) >= lane_x) && (CW'(i) < lane_end);
    assign host_data[i*8 +: 8] = (CW'(i) < nb) ? shifted[i*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
  import cfgb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_valid,
  input  logic                    host_write,
  input  logic [1:0]              host_size,
  input  logic [$clog2(DW/8)-1:0] host_lane,
  input  logic [DW-1:0]           host_wdata,
  input  logic                    hit_addr,
  input  logic                    hit_data,
  input  logic                    sel_en,
  input  logic [DW-1:0]           sel_word,
  input  logic                    req_ready,
  input  logic                    rsp_valid,
  input  logic [DW-1:0]           rsp_steered,
  output logic                    host_ready,
  output logic [DW-1:0]           host_rdata,
  output logic                    sel_we,
  output logic                    busy,
  output logic                    req_valid,
  output logic                    rsp_ready,
  output logic                    op_write,
  output logic [1:0]              op_size,
  output logic [$clog2(DW/8)-1:0] op_lane,
  output logic [DW-1:0]           op_wdata
);

  seq_state_e    state;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rdata_q  <= '0;
      op_write <= 1'b0;
      op_size  <= '0;
      op_lane  <= '0;
      op_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (host_valid) begin
          op_write <= host_write;
          op_size  <= host_size;
          op_lane  <= host_lane;
          op_wdata <= host_wdata;
          if (hit_data && sel_en) begin
            state <= ST_REQ;
          end else begin
            state   <= ST_DONE;
            rdata_q <= (hit_addr && !host_write) ? sel_word : '1;
          end
        end
        ST_REQ:  if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          rdata_q <= op_write ? '1 : rsp_steered;
          state   <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sel_we     = (state == ST_IDLE) && host_valid && hit_addr && host_write &&
                      (acc_size_e'(host_size) == SZ_WORD);
  assign busy       = (state == ST_REQ) || (state == ST_WAIT);
  assign req_valid  = (state == ST_REQ);
  assign rsp_ready  = (state == ST_WAIT);
  assign host_ready = (state == ST_DONE);
  assign host_rdata = rdata_q;

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);

  // R8
  ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && rsp_valid) |=> host_ready);

  // R4
  no_req_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && host_valid && !sel_en) |=> !req_valid);

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
#(
  parameter int              DW        = 32,
  parameter int              IOW       = 16,
  parameter logic [IOW-1:0]  ADDR_PORT = 'h0CF8,
  parameter logic [IOW-1:0]  DATA_PORT = 'h0CFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_valid,
  output logic            host_ready,
  input  logic            host_write,
  input  logic [IOW-1:0]  host_addr,
  input  logic [1:0]      host_size,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            cfg_req_valid,
  input  logic            cfg_req_ready,
  output logic            cfg_req_write,
  output logic [31:0]     cfg_req_addr,
  output logic [DW/8-1:0] cfg_req_be,
  output logic [DW-1:0]   cfg_req_wdata,
  input  logic            cfg_rsp_valid,
  output logic            cfg_rsp_ready,
  input  logic [DW-1:0]   cfg_rsp_rdata
);

  localparam int LW = $clog2(DW / 8);

  logic          hit_addr, hit_data;
  logic          sel_we, sel_en, busy;
  logic [DW-1:0] sel_word;
  logic          op_write;
  logic [1:0]    op_size;
  logic [LW-1:0] op_lane;
  logic [DW-1:0] op_wdata;
  logic [DW-1:0] rsp_steered;

  assign hit_addr = host_addr[IOW-1:LW] == ADDR_PORT[IOW-1:LW];
  assign hit_data = host_addr[IOW-1:LW] == DATA_PORT[IOW-1:LW];

  cfgb_sel_reg #(.DW(DW)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (sel_we),
    .wdata    (host_wdata),
    .busy     (busy),
    .sel_en   (sel_en),
    .sel_word (sel_word),
    .req_addr (cfg_req_addr)
  );

  cfgb_seq #(.DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_valid  (host_valid),
    .host_write  (host_write),
    .host_size   (host_size),
    .host_lane   (host_addr[LW-1:0]),
    .host_wdata  (host_wdata),
    .hit_addr    (hit_addr),
    .hit_data    (hit_data),
    .sel_en      (sel_en),
    .sel_word    (sel_word),
    .req_ready   (cfg_req_ready),
    .rsp_valid   (cfg_rsp_valid),
    .rsp_steered (rsp_steered),
    .host_ready  (host_ready),
    .host_rdata  (host_rdata),
    .sel_we      (sel_we),
    .busy        (busy),
    .req_valid   (cfg_req_valid),
    .rsp_ready   (cfg_rsp_ready),
    .op_write    (op_write),
    .op_size     (op_size),
    .op_lane     (op_lane),
    .op_wdata    (op_wdata)
  );

  cfgb_lane #(.DW(DW)) u_lane (
    .lane      (op_lane),
    .size      (op_size),
    .wdata     (op_wdata),
    .rsp_data  (cfg_rsp_rdata),
    .be        (cfg_req_be),
    .req_wdata (cfg_req_wdata),
    .host_data (rsp_steered)
  );

  assign cfg_req_write = op_write;

  // R5
  be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (cfg_req_be != '0));

  // R8
  req_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_req_ready) |=>
      ($stable(cfg_req_addr) && $stable(cfg_req_be) && $stable(cfg_req_wdata)));

endmodule

// File: tb/tb_cfg_port_bridge.sv
module tb_cfg_port_bridge;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_valid, host_write;
  logic        host_ready;
  logic [15:0] host_addr;
  logic [1:0]  host_size;
  logic [31:0] host_wdata, host_rdata;
  logic        cfg_req_valid, cfg_req_ready, cfg_req_write;
  logic [31:0] cfg_req_addr, cfg_req_wdata;
  logic [3:0]  cfg_req_be;
  logic        cfg_rsp_valid, cfg_rsp_ready;
  logic [31:0] cfg_rsp_rdata;

  always #5 clk = ~clk;

  cfg_port_bridge dut (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_write(cfg_req_write), .cfg_req_addr(cfg_req_addr),
    .cfg_req_be(cfg_req_be), .cfg_req_wdata(cfg_req_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_ready(cfg_rsp_ready),
    .cfg_rsp_rdata(cfg_rsp_rdata)
  );

  typedef struct {
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    string       tag;
  } req_item_t;

  req_item_t exp_q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rsp_fn(input logic [31:0] a);
    return {a[7:0] ^ 8'h4C, a[15:8] ^ 8'h93, a[23:16] ^ 8'hE7, a[31:24] ^ 8'h2B};
  endfunction

  function automatic logic [31:0] steer(input logic [31:0] d, input logic [1:0] lane,
                                        input logic [1:0] sz);
    logic [31:0] s;
    s = d >> (8 * lane);
    if (sz == 2'd0) return s & 32'h0000_00FF;
    if (sz == 2'd1) return s & 32'h0000_FFFF;
    return s;
  endfunction

  function automatic logic [3:0] be_of(input logic [1:0] lane, input logic [1:0] sz);
    logic [7:0] m;
    m = (sz == 2'd0) ? 8'h01 : (sz == 2'd1) ? 8'h03 : 8'h0F;
    m = m << lane;
    return m[3:0];
  endfunction

  // Target model: accepts requests and answers after a varying delay.
  int dly = 0;
  logic [31:0] tgt_addr;
  initial begin
    cfg_req_ready = 1'b0;
    cfg_rsp_valid = 1'b0;
    cfg_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (cfg_req_valid) begin
        repeat (dly) @(negedge clk);
        cfg_req_ready = 1'b1;
        tgt_addr = cfg_req_addr;
        @(negedge clk);
        cfg_req_ready = 1'b0;
        repeat (dly) @(negedge clk);
        cfg_rsp_rdata = rsp_fn(tgt_addr);
        cfg_rsp_valid = 1'b1;
        @(negedge clk);
        cfg_rsp_valid = 1'b0;
        dly = (dly + 1) % 3;
      end
    end
  end

  // Monitor: every accepted request must match the head of the queue.
  always @(posedge clk) begin
    if (rst_n && cfg_req_valid && cfg_req_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8/R4 unexpected request", cfg_req_addr, 32'h0);
      end else begin
        req_item_t e;
        e = exp_q.pop_front();
        chk(cfg_req_addr == e.addr, {e.tag, " addr"}, cfg_req_addr, e.addr);
        chk(cfg_req_be == e.be, "R5 byte enables", {28'h0, cfg_req_be}, {28'h0, e.be});
        chk(cfg_req_write == e.wr, "R8 direction", {31'h0, cfg_req_write}, {31'h0, e.wr});
        if (e.wr) chk(cfg_req_wdata == e.wdata, "R6 write data", cfg_req_wdata, e.wdata);
      end
    end
  end

  task automatic access(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_addr = a; host_size = sz; host_wdata = wd;
    do @(negedge clk); while (!host_ready);
    rd = host_rdata;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic set_sel(input logic [31:0] w);
    logic [31:0] rd;
    access(1'b1, 16'h0CF8, 2'd2, w, rd);
    access(1'b0, 16'h0CF8, 2'd2, 32'h0, rd);
    chk(rd == (w & 32'h80FF_FFFC), "R1 selector readback", rd, w & 32'h80FF_FFFC);
  endtask

  // Driver: pushes the expected request, performs the access, checks the result.
  task automatic data_acc(input logic wr, input logic [1:0] lane, input logic [1:0] sz,
                          input logic [31:0] wd, input bit expect_req,
                          input logic [31:0] exp_addr, input string tag);
    logic [31:0] rd;
    if (expect_req) begin
      req_item_t e;
      e.wr = wr; e.addr = exp_addr; e.be = be_of(lane, sz);
      e.wdata = wd << (8 * lane); e.tag = tag;
      exp_q.push_back(e);
    end
    access(wr, 16'h0CFC + {14'h0, lane}, sz, wd, rd);
    chk(exp_q.size() == 0, "R8 one request per access", exp_q.size(), 0);
    if (!wr) begin
      if (expect_req) chk(rd == steer(rsp_fn(exp_addr), lane, sz), "R7 read steering",
                          rd, steer(rsp_fn(exp_addr), lane, sz));
      else chk(rd == 32'hFFFF_FFFF, "R4 disabled read", rd, 32'hFFFF_FFFF);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0;
    host_valid = 1'b0; host_write = 1'b0; host_addr = '0; host_size = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(host_ready == 1'b0, "R11 host_ready after reset", {31'h0, host_ready}, 32'h0);
    chk(cfg_req_valid == 1'b0, "R11 req_valid after reset", {31'h0, cfg_req_valid}, 32'h0);
    access(1'b0, 16'h0CF8, 2'd2, 32'h0, rd);
    chk(rd == 32'h0, "R11 selector after reset", rd, 32'h0);

    // R4: enable clear
    data_acc(1'b0, 2'd0, 2'd2, 32'h0, 1'b0, 32'h0, "R4");
    data_acc(1'b1, 2'd0, 2'd2, 32'hDEAD_BEEF, 1'b0, 32'h0, "R4");

    // R1: masking
    set_sel(32'hFFFF_FFFF);

    // R2: type 0, dev 3 fn 5 reg 0x11
    set_sel(32'h8000_1D44);
    data_acc(1'b0, 2'd0, 2'd2, 32'h0, 1'b1, 32'h0000_1D44, "R2 type0");
    for (int l = 0; l < 4; l++)
      data_acc(1'b0, l[1:0], 2'd0, 32'h0, 1'b1, 32'h0000_1D44, "R2 type0 byte");
    data_acc(1'b0, 2'd0, 2'd1, 32'h0, 1'b1, 32'h0000_1D44, "R2 type0 half");
    data_acc(1'b0, 2'd2, 2'd1, 32'h0, 1'b1, 32'h0000_1D44, "R2 type0 half");

    // R3: type 1, bus 0x2A dev 31 fn 7 reg 63, junk in reserved bits
    set_sel(32'hFF2A_FFFF);
    data_acc(1'b0, 2'd0, 2'd2, 32'h0, 1'b1, 32'h002A_FFFD, "R3 type1");
    data_acc(1'b0, 2'd3, 2'd0, 32'h0, 1'b1, 32'h002A_FFFD, "R3 type1 byte");

    // R5 R6: writes at lanes
    data_acc(1'b1, 2'd1, 2'd0, 32'h0000_00AB, 1'b1, 32'h002A_FFFD, "R6 byte write");
    data_acc(1'b1, 2'd2, 2'd1, 32'h0000_1234, 1'b1, 32'h002A_FFFD, "R6 half write");
    data_acc(1'b1, 2'd0, 2'd2, 32'hCAFE_F00D, 1'b1, 32'h002A_FFFD, "R6 word write");
    data_acc(1'b0, 2'd3, 2'd1, 32'h0, 1'b1, 32'h002A_FFFD, "R5 half at lane 3");

    // R10: partial address-port write ignored, foreign address ignored
    access(1'b1, 16'h0CF8, 2'd0, 32'h0000_0000, rd);
    access(1'b0, 16'h0CF8, 2'd2, 32'h0, rd);
    chk(rd == 32'h802A_FFFC, "R10 partial write ignored", rd, 32'h802A_FFFC);
    access(1'b1, 16'h0CF0, 2'd2, 32'h0000_0000, rd);
    access(1'b0, 16'h0CF0, 2'd2, 32'h0, rd);
    chk(rd == 32'hFFFF_FFFF, "R10 foreign read", rd, 32'hFFFF_FFFF);
    chk(exp_q.size() == 0, "R10 no request from foreign address", exp_q.size(), 0);
    access(1'b0, 16'h0CF8, 2'd2, 32'h0, rd);
    chk(rd == 32'h802A_FFFC, "R10 selector unchanged", rd, 32'h802A_FFFC);

    // R9: selector stays put across traffic; disable again
    set_sel(32'h0005_0800);
    data_acc(1'b0, 2'd1, 2'd0, 32'h0, 1'b0, 32'h0, "R4 re-disabled");

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule